// File: doc/BRIEF.md
# Banked Interrupt Controller with Per-Source Trigger Control

This block gathers raw interrupt inputs into banks of 32 sources each. It produces one request line per bank for the processor. For each bank, software sees one group of word registers. Through these registers software picks a trigger style for each source, either edge or level. It also picks the active sense of each source with a single polarity bit. Software enables sources, forces them pending and acknowledges them. A bank raises its request line while any enabled source is pending.

Each bank also presents the index of its lowest-numbered pending-and-enabled source. This lets a dispatcher go straight to a handler without scanning. A source with global number `n` lives in bank `n >> 5` at bit `n & 31`. Raw inputs are brought into the clock domain through a two-stage synchroniser, and edges are detected on the synchronised value.

The default build has five banks. Request line `k` is meant for processor interrupt input `k + 2`. Arbitration between bank lines belongs to the processor, not to this block.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Bank `b` occupies byte addresses `b*0x18` to `b*0x18+0x17`, and one address port serves both reads and writes. Within a bank the offsets are: 0x00 status (read only), 0x04 enable (read/write), 0x08 force (write-one, reads 0), 0x0C acknowledge (write-one, reads 0), 0x10 polarity (read/write) and 0x14 mode (read/write). A read of an address beyond the last bank returns 0.
- R2: `bank_irq[b]` is 1 exactly when the bitwise AND of bank `b`'s status and enable registers is nonzero. A source whose enable bit is 0 never raises the line.
- R3: `pend_idx` field `b` (bits `b*5+4` down to `b*5`) gives the lowest bit position that is set in status AND enable. It reads 0 when no bit is set.
- R4: A source whose mode bit is 1 is edge triggered. With polarity 1 it latches on a rising input, and with polarity 0 on a falling input. The status bit reads 1 three clock edges after the input changes, and it stays 1 until acknowledged. The opposite edge has no effect.
- R5: Writing 1 to an acknowledge bit clears that source's latched status on the write edge. If a new edge event is detected on that same edge, the event wins and the status stays 1.
- R6: A source whose mode bit is 0 is level triggered. Its status is 1 while the input equals the polarity bit (1 = active high, 0 = active low), and it follows the input two clock edges after an input change. An acknowledge has no lasting effect while the input stays active.
- R7: Writing 1 to a force bit sets that source's latched status in either mode, and it stays set until acknowledged. Force bits written as 0 change nothing.
- R8: After reset, every enable, polarity, mode and latched bit is 0. So with all inputs low, every source reads as an active-low level source with status 1, and no request line is raised.
- R9: Writing the polarity or mode register never by itself latches an edge event. Events come only from changes of the synchronised input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | NUM_BANKS*32 | Raw interrupt inputs, bit `b*32+i` is bank `b` source `i` |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (7) | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| bank_irq | output | NUM_BANKS | Per-bank request lines |
| pend_idx | output | NUM_BANKS*5 | Per-bank lowest pending source index |

## Verification
Register writes take effect on the clock edge that samples `reg_we`. Read data, request lines and indices are combinational from the registers, so they are sampled on the falling edge after that write edge. A level input shows in status two rising edges after it changes, and an edge input latches on the third. The bench times each input change from a known phase and samples on exactly those edges. It also places a "not yet" check one edge early, and it lines up an acknowledge write with the third edge to test the same-edge collision. Every expected item is queued by the driver when its stimulus has been issued, and the monitor compares it at the next falling edge.

// File: rtl/ibc_pkg.sv
`timescale 1ns/1ps
package ibc_pkg;
  // Byte distance between consecutive bank register groups
  localparam int unsigned REG_STRIDE = 24;
  // Register width and therefore sources per bank
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned OFS_W      = 5;

  // Offsets inside one bank group
  localparam logic [OFS_W-1:0] OFS_STATUS = 5'h00;
  localparam logic [OFS_W-1:0] OFS_ENABLE = 5'h04;
  localparam logic [OFS_W-1:0] OFS_FORCE  = 5'h08;
  localparam logic [OFS_W-1:0] OFS_ACK    = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_POLAR  = 5'h10;
  localparam logic [OFS_W-1:0] OFS_MODE   = 5'h14;

  typedef struct packed {
    logic [DATA_W-1:0] enable;
    logic [DATA_W-1:0] polar;
    logic [DATA_W-1:0] mode;
    logic [DATA_W-1:0] latched;
    logic [DATA_W-1:0] prev;
  } bank_state_t;
endpackage

// File: rtl/ibc_sync.sv
`timescale 1ns/1ps
module ibc_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/ibc_first_one.sv
`timescale 1ns/1ps
module ibc_first_one #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  // Scan from the top so the lowest set position is the last one written
  always_comb begin
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o = |vec_i;
endmodule

// File: rtl/ibc_bank.sv
`timescale 1ns/1ps
module ibc_bank
  import ibc_pkg::*;
#(
  parameter int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_s_i,
  input  logic              wr_en_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  idx_o
);
  bank_state_t st_q;
  bank_state_t st_d;

  logic [DATA_W-1:0] force_mask;
  logic [DATA_W-1:0] ack_mask;
  logic [DATA_W-1:0] level_act;
  logic [DATA_W-1:0] rise;
  logic [DATA_W-1:0] fall;
  logic [DATA_W-1:0] edge_evt;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] pend;
  logic              en_we;
  logic              pol_we;
  logic              mode_we;

  // Write decode
  always_comb begin
    force_mask = (wr_en_i && (ofs_i == OFS_FORCE)) ? wdata_i : '0;
    ack_mask   = (wr_en_i && (ofs_i == OFS_ACK))   ? wdata_i : '0;
    en_we      = wr_en_i && (ofs_i == OFS_ENABLE);
    pol_we     = wr_en_i && (ofs_i == OFS_POLAR);
    mode_we    = wr_en_i && (ofs_i == OFS_MODE);
  end

  // Trigger detection on the synchronised input
  always_comb begin
    level_act = ~(src_s_i ^ st_q.polar);
    rise      = src_s_i & ~st_q.prev;
    fall      = ~src_s_i & st_q.prev;
    edge_evt  = st_q.mode & ((st_q.polar & rise) | (~st_q.polar & fall));
  end

  // Next state
  always_comb begin
    st_d         = st_q;
    st_d.prev    = src_s_i;
    st_d.latched = (st_q.latched & ~ack_mask) | edge_evt | force_mask;
    if (en_we)   st_d.enable = wdata_i;
    if (pol_we)  st_d.polar  = wdata_i;
    if (mode_we) st_d.mode   = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  // Visible status: latched events, plus the live level for level sources
  assign status = st_q.latched | (~st_q.mode & level_act);
  assign pend   = status & st_q.enable;

  ibc_first_one #(.WIDTH(DATA_W), .IDX_W(IDX_W)) u_first (
    .vec_i   (pend),
    .idx_o   (idx_o),
    .found_o (irq_o)
  );

  always_comb begin
    case (ofs_i)
      OFS_STATUS: rdata_o = status;
      OFS_ENABLE: rdata_o = st_q.enable;
      OFS_POLAR:  rdata_o = st_q.polar;
      OFS_MODE:   rdata_o = st_q.mode;
      default:    rdata_o = '0;
    endcase
  end

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(st_q.latched) & ~$past(ack_mask)) & ~st_q.latched) == '0)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ack_mask) & ~$past(edge_evt) & ~$past(force_mask)) & st_q.latched) == '0)); // R5
  AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(force_mask) & ~st_q.latched) == '0)); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.enable == '0) |-> !irq_o); // R2
  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend[idx_o] && ((pend & ((DATA_W'(1) << idx_o) - DATA_W'(1))) == '0))); // R3
  AST_CFG_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_s_i == st_q.prev) |-> (edge_evt == '0)); // R9
endmodule

// File: rtl/irq_bank_ctrl.sv
`timescale 1ns/1ps
module irq_bank_ctrl
  import ibc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned IDX_W     = $clog2(DATA_W),
  parameter int unsigned ADDR_W    = $clog2(NUM_BANKS * REG_STRIDE + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*DATA_W-1:0] src_i,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  output logic [NUM_BANKS-1:0]        bank_irq,
  output logic [NUM_BANKS*IDX_W-1:0]  pend_idx
);
  localparam int unsigned SRC_TOTAL = NUM_BANKS * DATA_W;
  localparam int unsigned MAP_END   = NUM_BANKS * REG_STRIDE;

  logic [SRC_TOTAL-1:0] src_sync;
  logic [31:0]          addr_ext;
  logic [NUM_BANKS-1:0] hit;
  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];

  assign addr_ext = 32'(reg_addr);

  ibc_sync #(.WIDTH(SRC_TOTAL)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_i),
    .sync_o  (src_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned BASE = b * REG_STRIDE;
    logic [OFS_W-1:0] ofs;

    assign hit[b] = (addr_ext >= BASE) && (addr_ext < BASE + REG_STRIDE);
    assign ofs    = OFS_W'(addr_ext - BASE);

    ibc_bank #(.IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_s_i (src_sync[b*DATA_W +: DATA_W]),
      .wr_en_i (reg_we && hit[b]),
      .ofs_i   (ofs),
      .wdata_i (reg_wdata),
      .rdata_o (bank_rd[b]),
      .irq_o   (bank_irq[b]),
      .idx_o   (pend_idx[b*IDX_W +: IDX_W])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      reg_rdata = reg_rdata | (bank_rd[b] & {DATA_W{hit[b]}});
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ext >= MAP_END) |-> (reg_rdata == '0)); // R1
  AST_SINGLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R1
endmodule

// File: tb/irq_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_bank_ctrl_tb_top;
  import ibc_pkg::*;

  localparam int NB = 5;
  localparam int AW = 7;
  localparam int IW = 5;

  typedef enum logic [1:0] {K_RD, K_IRQ, K_IDX} kind_e;
  typedef struct {
    kind_e       kind;
    int          bank;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic             clk;
  logic             rst_n;
  logic [NB*32-1:0] src_i;
  logic             reg_we;
  logic [AW-1:0]    reg_addr;
  logic [31:0]      reg_wdata;
  logic [31:0]      reg_rdata;
  logic [NB-1:0]    bank_irq;
  logic [NB*IW-1:0] pend_idx;

  item_t sb_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;

  irq_bank_ctrl #(.NUM_BANKS(NB)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .bank_irq  (bank_irq),
    .pend_idx  (pend_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input int b, input logic [4:0] ofs, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr  = AW'(b * 24 + int'(ofs));
    reg_wdata = d;
    reg_we    = 1'b1;
    @(posedge clk); #1;
    reg_we    = 1'b0;
  endtask

  task automatic drive(input int idx, input logic v);
    @(posedge clk); #1;
    src_i[idx] = v;
  endtask

  // Driver side of the scoreboard: set up the observation, queue the expectation
  task automatic chk(input kind_e k, input int b, input logic [4:0] ofs,
                     input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    if (k == K_RD) reg_addr = AW'(b * 24 + int'(ofs));
    it.kind = k;
    it.bank = b;
    it.exp  = e;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  // Monitor side: pop and compare away from the active edge
  item_t       mon_it;
  logic [31:0] mon_act;
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      mon_it = sb_q.pop_front();
      case (mon_it.kind)
        K_RD:    mon_act = reg_rdata;
        K_IRQ:   mon_act = {31'b0, bank_irq[mon_it.bank]};
        default: mon_act = {27'b0, pend_idx[mon_it.bank*IW +: IW]};
      endcase
      n_vec++;
      if (mon_act !== mon_it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", mon_it.tag, mon_act, mon_it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    src_i     = '0;
    reg_we    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    tick(3);
    #1 rst_n = 1'b1;

    // Reset state
    chk(K_RD,  0, OFS_ENABLE, 32'h0,        "R8 enable after reset");
    chk(K_RD,  0, OFS_STATUS, 32'hFFFF_FFFF, "R8 active-low status after reset");
    chk(K_IRQ, 0, 0,          32'h0,        "R8 R2 no request after reset");

    // Software-style initialisation
    for (int b = 0; b < NB; b++) wr(b, OFS_POLAR, 32'hFFFF_FFFF);
    wr(0, OFS_MODE, 32'h0000_E000);
    chk(K_RD, 0, OFS_STATUS, 32'h0,         "R6 high-level idle status");
    chk(K_RD, 0, OFS_MODE,   32'h0000_E000, "R1 mode readback");

    // Level source, bank 2 bit 5
    wr(2, OFS_ENABLE, 32'hFFFF_FFFF);
    drive(2*32+5, 1'b1);
    chk(K_IRQ, 2, 0,          32'h0,  "R6 one edge is too early");
    chk(K_RD,  2, OFS_STATUS, 32'h20, "R6 level status after two edges");
    chk(K_IRQ, 2, 0,          32'h1,  "R2 bank2 request");
    chk(K_IDX, 2, 0,          32'd5,  "R3 bank2 index");
    wr(2, OFS_ACK, 32'h20);
    chk(K_RD,  2, OFS_STATUS, 32'h20, "R6 ack ignored while active");
    drive(2*32+5, 1'b0);
    tick(1);
    chk(K_RD,  2, OFS_STATUS, 32'h0,  "R6 level released");
    chk(K_IRQ, 2, 0,          32'h0,  "R2 bank2 request dropped");

    // Edge sources in bank 0
    wr(0, OFS_ENABLE, 32'h6000);
    drive(13, 1'b1);
    tick(1);
    chk(K_RD, 0, OFS_STATUS, 32'h0,    "R4 rising not latched after two edges");
    chk(K_RD, 0, OFS_STATUS, 32'h2000, "R4 rising latched on third edge");
    drive(13, 1'b0);
    tick(3);
    chk(K_RD, 0, OFS_STATUS, 32'h2000, "R4 latch holds after input falls");
    wr(0, OFS_POLAR, ~32'h4000);
    chk(K_RD, 0, OFS_STATUS, 32'h2000, "R9 polarity write makes no event");
    drive(14, 1'b1);
    tick(3);
    chk(K_RD, 0, OFS_STATUS, 32'h2000, "R4 rising ignored in falling mode");
    drive(14, 1'b0);
    tick(2);
    chk(K_RD,  0, OFS_STATUS, 32'h6000, "R4 falling edge latched");
    chk(K_IDX, 0, 0,          32'd13,   "R3 lowest of two pending");
    wr(0, OFS_ACK, 32'h2000);
    chk(K_RD,  0, OFS_STATUS, 32'h4000, "R5 ack clears one bit");
    chk(K_IDX, 0, 0,          32'd14,   "R3 index moves up");
    wr(0, OFS_ACK, 32'h4000);
    chk(K_RD,  0, OFS_STATUS, 32'h0,    "R5 ack clears last bit");
    chk(K_IRQ, 0, 0,          32'h0,    "R2 bank0 quiet");
    chk(K_IDX, 0, 0,          32'd0,    "R3 index zero when idle");

    // Ack on the same edge as a new event
    drive(13, 1'b1);
    tick(1);
    wr(0, OFS_ACK, 32'h2000);
    chk(K_RD, 0, OFS_STATUS, 32'h2000, "R5 event wins over same-edge ack");
    wr(0, OFS_ACK, 32'h2000);
    chk(K_RD, 0, OFS_STATUS, 32'h0,    "R5 later ack clears");
    drive(13, 1'b0);

    // Forcing, bank 3
    wr(3, OFS_ENABLE, 32'h8000_0001);
    wr(3, OFS_FORCE,  32'h8000_0000);
    chk(K_RD,  3, OFS_STATUS, 32'h8000_0000, "R7 force sets status");
    chk(K_IDX, 3, 0,          32'd31,        "R3 index of top bit");
    chk(K_IRQ, 3, 0,          32'h1,         "R2 bank3 request");
    wr(3, OFS_FORCE, 32'h0);
    chk(K_RD,  3, OFS_STATUS, 32'h8000_0000, "R7 zero force no effect");
    chk(K_RD,  3, OFS_FORCE,  32'h0,         "R1 force reads zero");
    wr(3, OFS_ACK, 32'h8000_0000);
    chk(K_RD,  3, OFS_STATUS, 32'h0,         "R7 forced bit acknowledged");
    chk(K_IRQ, 3, 0,          32'h0,         "R2 bank3 quiet");

    // Enable masking, bank 4
    drive(4*32, 1'b1);
    tick(1);
    chk(K_RD,  4, OFS_STATUS, 32'h1, "R2 status visible while disabled");
    chk(K_IRQ, 4, 0,          32'h0, "R2 disabled source no request");
    wr(4, OFS_ENABLE, 32'h1);
    chk(K_IRQ, 4, 0,          32'h1, "R2 enabled source requests");
    chk(K_RD,  4, OFS_ENABLE, 32'h1, "R1 bank4 enable readback");
    chk(K_RD,  5, 0,          32'h0, "R1 unmapped read zero");

    // Index selection with enable filtering, bank 1
    drive(32+7, 1'b1);
    drive(32+3, 1'b1);
    tick(1);
    wr(1, OFS_ENABLE, 32'h80);
    chk(K_IDX, 1, 0, 32'd7, "R3 masked lower source skipped");
    wr(1, OFS_ENABLE, 32'hFFFF_FFFF);
    chk(K_IDX, 1, 0, 32'd3, "R3 lowest enabled source");
    chk(K_IRQ, 1, 0, 32'h1, "R2 bank1 request");

    tick(3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule